// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Unit with Modulo Index Stepping

This block is the arithmetic core of a signal-processing path that works on signed fractional numbers. Two 16-bit operand registers hold Q1.15 values. A start strobe multiplies them, scales the product into the Q1.31 frame, and adds it into a 36-bit accumulator. The accumulator carries four guard bits above its sign bit, so a long sum can grow past the ±1.0 range and still be recovered later. Software-visible state is limited to the accumulator, which is loaded and read as a 20-bit upper field and a 16-bit lower field, and to two sticky overflow flags.

Saturation is chosen per operation by a mode input. With saturation off, the accumulator keeps the 36-bit two's-complement sum. With saturation on, any sum that leaves the 32-bit fraction range is pinned to the largest or smallest fraction, according to the sign of the true result. Each executed multiply-accumulate also steps two table indices, x and y, by their own increments. Only the bits selected by each index's 8-bit mask change, so the indices walk a power-of-two coefficient table and wrap at its end.

Top module: `frac_mac`

## Requirements
- R1: While reset is asserted, and until reset has been released for two clock edges, the accumulator, both flags, both indices, both masks and both operand registers read zero.
- R2: An operand register takes its load data at the clock edge where its load strobe is high and holds it until the next load. Two starts with no reload in between add the same product twice.
- R3: At a clock edge with mac_start high and no accumulator load, the accumulator becomes its previous value plus (op_a × op_b × 2) sign-extended to 36 bits. The result is visible after that edge. With no start and no load, the accumulator holds.
- R4: The accumulator's bits 35..16 are read on acc_hi and bits 15..0 on acc_lo. Each half is written by its own load strobe, and a load of one half leaves the other half unchanged.
- R5: A load of either accumulator half at the same edge as mac_start takes priority. The multiply-accumulate is dropped: the accumulator takes only the loaded data, and the indices and flags do not change from it.
- R6: With sat_en low, the stored result is the true sum modulo 2^36.
- R7: With sat_en high, a true sum above 0x0_7FFF_FFFF stores 0x0_7FFF_FFFF, and a true sum below 0xF_8000_0000 (−2^31) stores 0xF_8000_0000.
- R8: ovf_ext is set by any executed multiply-accumulate whose true sum lies outside [−2^31, 2^31−1], in either saturation mode, and stays set until cleared.
- R9: ovf_mac is set by any executed multiply-accumulate whose true sum lies outside [−2^35, 2^35−1], and stays set until cleared.
- R10: flag_clr high at an edge clears both flags. Clearing wins over a set at the same edge.
- R11: mask_data[15:8] is the x mask and mask_data[7:0] is the y mask. On each executed multiply-accumulate, each index becomes (idx & ~mask) | ((idx + step) & mask). Bits outside the mask never change.
- R12: idx_load loads both indices. It has priority over the step from a start at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_a_load | input | 1 | Load strobe for operand A |
| op_a_data | input | 16 | Operand A value, Q1.15 |
| op_b_load | input | 1 | Load strobe for operand B |
| op_b_data | input | 16 | Operand B value, Q1.15 |
| acc_hi_load | input | 1 | Load strobe for accumulator bits 35..16 |
| acc_hi_data | input | 20 | Data for accumulator bits 35..16 |
| acc_lo_load | input | 1 | Load strobe for accumulator bits 15..0 |
| acc_lo_data | input | 16 | Data for accumulator bits 15..0 |
| mac_start | input | 1 | Execute one multiply-accumulate |
| sat_en | input | 1 | 1 = clamp to fraction range, 0 = wrap |
| flag_clr | input | 1 | Clear both overflow flags |
| mask_load | input | 1 | Load strobe for both index masks |
| mask_data | input | 16 | x mask in [15:8], y mask in [7:0] |
| idx_load | input | 1 | Load strobe for both indices |
| idx_x_data | input | 8 | x index load value |
| idx_y_data | input | 8 | y index load value |
| step_x | input | 8 | x index increment |
| step_y | input | 8 | y index increment |
| acc_hi | output | 20 | Accumulator bits 35..16 |
| acc_lo | output | 16 | Accumulator bits 15..0 |
| ovf_mac | output | 1 | Sticky 36-bit overflow flag |
| ovf_ext | output | 1 | Sticky fraction-range overflow flag |
| idx_x | output | 8 | Current x index |
| idx_y | output | 8 | Current y index |

## Verification
The bench targets −1 × −1, whose product is exactly +1.0 and falls just outside the fraction range. A design that skipped sign extension before the shift would wrap it to −1.0. It also drives sums past the 36-bit limits in both directions. A design that judged the clamp direction from the wrapped bits instead of the true sign would saturate to the wrong rail there. Other cases: a flag set and clear in the same cycle, where a wrong priority leaves a flag standing; an accumulator load colliding with a start, where a leaky design advances the indices; and index steps that carry across the mask edge, where a plain adder corrupts the bits above the table.

// File: rtl/frac_mac_pkg.sv
package frac_mac_pkg;

  typedef enum logic {
    SAT_WRAP  = 1'b0,
    SAT_CLAMP = 1'b1
  } sat_mode_e;

  typedef struct packed {
    logic wide;   // 36-bit two's complement overflow
    logic frac;   // left the 32-bit fraction range
  } ovf_flags_t;

endpackage

// File: rtl/frac_mac_rst_sync.sv
module frac_mac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/frac_mac_product.sv
module frac_mac_product #(
  parameter  int OP_W  = 16,
  parameter  int ACC_W = 36,
  localparam int PRD_W = 2 * OP_W
) (
  input  logic [OP_W-1:0]  mult_a,
  input  logic [OP_W-1:0]  mult_b,
  output logic [ACC_W-1:0] addend
);

  logic signed [PRD_W-1:0] prod;
  logic        [ACC_W-1:0] prod_ext;

  always_comb begin
    prod     = $signed(mult_a) * $signed(mult_b);
    // Sign-extend first, then shift, so that -1 x -1 becomes +1.0 in the guard bits
    prod_ext = {{(ACC_W-PRD_W){prod[PRD_W-1]}}, prod};
    addend   = {prod_ext[ACC_W-2:0], 1'b0};
  end

endmodule

// File: rtl/frac_mac_accum.sv
module frac_mac_accum
  import frac_mac_pkg::*;
#(
  parameter  int ACC_W  = 36,
  parameter  int FRAC_W = 31,
  parameter  int LO_W   = 16,
  localparam int HI_W   = ACC_W - LO_W,
  localparam int SUM_W  = ACC_W + 1,
  localparam int TOP_W  = SUM_W - FRAC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             sat_en,
  input  logic             hi_load,
  input  logic [HI_W-1:0]  hi_data,
  input  logic             lo_load,
  input  logic [LO_W-1:0]  lo_data,
  input  logic [ACC_W-1:0] addend,
  input  logic             flag_clr,
  output logic [ACC_W-1:0] acc,
  output logic             ovf_wide,
  output logic             ovf_frac
);

  sat_mode_e        mode;
  logic [SUM_W-1:0] sum;
  logic [TOP_W-1:0] top_bits;
  logic             out_rng;
  logic             wide_ovf;
  logic [ACC_W-1:0] clamp_v;
  logic [ACC_W-1:0] mac_v;
  logic [ACC_W-1:0] acc_d, acc_q;
  logic             acc_en;
  ovf_flags_t       flg_d, flg_q;
  logic             flg_en;

  // Arithmetic: true sum carries one extra bit so its sign is never lost
  always_comb begin
    mode     = sat_mode_e'(sat_en);
    sum      = {acc_q[ACC_W-1], acc_q} + {addend[ACC_W-1], addend};
    top_bits = sum[SUM_W-1:FRAC_W];
    out_rng  = !((&top_bits) || !(|top_bits));
    wide_ovf = sum[SUM_W-1] ^ sum[SUM_W-2];
    clamp_v  = sum[SUM_W-1] ? {{(ACC_W-FRAC_W){1'b1}}, {FRAC_W{1'b0}}}
                            : {{(ACC_W-FRAC_W){1'b0}}, {FRAC_W{1'b1}}};
    mac_v    = (mode == SAT_CLAMP && out_rng) ? clamp_v : sum[ACC_W-1:0];
  end

  // Accumulator next state: direct loads outrank the multiply-accumulate
  always_comb begin
    acc_d  = acc_q;
    acc_en = hi_load | lo_load | fire;
    if (hi_load || lo_load) begin
      if (hi_load) acc_d[ACC_W-1:LO_W] = hi_data;
      if (lo_load) acc_d[LO_W-1:0]     = lo_data;
    end else if (fire) begin
      acc_d = mac_v;
    end
  end

  // Flag next state: clear outranks set
  always_comb begin
    flg_en = flag_clr | fire;
    if (flag_clr) begin
      flg_d = '0;
    end else begin
      flg_d.wide = flg_q.wide | wide_ovf;
      flg_d.frac = flg_q.frac | out_rng;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q <= '0;
    end else if (flg_en) begin
      flg_q <= flg_d;
    end
  end

  assign acc      = acc_q;
  assign ovf_wide = flg_q.wide;
  assign ovf_frac = flg_q.frac;

endmodule

// File: rtl/frac_mac_index.sv
module frac_mac_index #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mask_load,
  input  logic [IDX_W-1:0] mask_data,
  input  logic             idx_load,
  input  logic [IDX_W-1:0] idx_data,
  input  logic [IDX_W-1:0] step,
  input  logic             advance,
  output logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] mask
);

  logic [IDX_W-1:0] idx_d, idx_q;
  logic [IDX_W-1:0] mask_q;
  logic [IDX_W-1:0] bumped;
  logic             idx_en;

  always_comb begin
    bumped = idx_q + step;
    idx_en = idx_load | advance;
    if (idx_load) begin
      idx_d = idx_data;
    end else begin
      idx_d = (idx_q & ~mask_q) | (bumped & mask_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_load) begin
      mask_q <= mask_data;
    end
  end

  assign idx  = idx_q;
  assign mask = mask_q;

endmodule

// File: rtl/frac_mac.sv
module frac_mac #(
  parameter  int OP_W    = 16,
  parameter  int GUARD_W = 4,
  parameter  int IDX_W   = 8,
  parameter  int LO_W    = 16,
  localparam int FRAC_W  = 2 * OP_W - 1,
  localparam int ACC_W   = FRAC_W + 1 + GUARD_W,
  localparam int HI_W    = ACC_W - LO_W,
  localparam int AXES    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_a_load,
  input  logic [OP_W-1:0]    op_a_data,
  input  logic               op_b_load,
  input  logic [OP_W-1:0]    op_b_data,
  input  logic               acc_hi_load,
  input  logic [HI_W-1:0]    acc_hi_data,
  input  logic               acc_lo_load,
  input  logic [LO_W-1:0]    acc_lo_data,
  input  logic               mac_start,
  input  logic               sat_en,
  input  logic               flag_clr,
  input  logic               mask_load,
  input  logic [2*IDX_W-1:0] mask_data,
  input  logic               idx_load,
  input  logic [IDX_W-1:0]   idx_x_data,
  input  logic [IDX_W-1:0]   idx_y_data,
  input  logic [IDX_W-1:0]   step_x,
  input  logic [IDX_W-1:0]   step_y,
  output logic [HI_W-1:0]    acc_hi,
  output logic [LO_W-1:0]    acc_lo,
  output logic               ovf_mac,
  output logic               ovf_ext,
  output logic [IDX_W-1:0]   idx_x,
  output logic [IDX_W-1:0]   idx_y
);

  logic                        rst_sync_n;
  logic [OP_W-1:0]             op_a_q, op_b_q;
  logic [ACC_W-1:0]            addend;
  logic [ACC_W-1:0]            acc;
  logic                        mac_fire;
  logic [AXES-1:0][IDX_W-1:0]  mask_in, idx_in, step_in, idx_out, mask_out;
  logic [IDX_W-1:0]            mask_x_q, mask_y_q;

  frac_mac_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  // Operand registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      op_a_q <= '0;
    end else if (op_a_load) begin
      op_a_q <= op_a_data;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      op_b_q <= '0;
    end else if (op_b_load) begin
      op_b_q <= op_b_data;
    end
  end

  // A start colliding with an accumulator load is dropped entirely
  assign mac_fire = mac_start & ~acc_hi_load & ~acc_lo_load;

  frac_mac_product #(.OP_W(OP_W), .ACC_W(ACC_W)) u_product (
    .mult_a (op_a_q),
    .mult_b (op_b_q),
    .addend (addend)
  );

  frac_mac_accum #(.ACC_W(ACC_W), .FRAC_W(FRAC_W), .LO_W(LO_W)) u_accum (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .fire     (mac_fire),
    .sat_en   (sat_en),
    .hi_load  (acc_hi_load),
    .hi_data  (acc_hi_data),
    .lo_load  (acc_lo_load),
    .lo_data  (acc_lo_data),
    .addend   (addend),
    .flag_clr (flag_clr),
    .acc      (acc),
    .ovf_wide (ovf_mac),
    .ovf_frac (ovf_ext)
  );

  // Axis 1 = x, axis 0 = y
  assign mask_in = {mask_data[2*IDX_W-1:IDX_W], mask_data[IDX_W-1:0]};
  assign idx_in  = {idx_x_data, idx_y_data};
  assign step_in = {step_x, step_y};

  for (genvar g = 0; g < AXES; g++) begin : g_axis
    frac_mac_index #(.IDX_W(IDX_W)) u_index (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .mask_load (mask_load),
      .mask_data (mask_in[g]),
      .idx_load  (idx_load),
      .idx_data  (idx_in[g]),
      .step      (step_in[g]),
      .advance   (mac_fire),
      .idx       (idx_out[g]),
      .mask      (mask_out[g])
    );
  end

  assign idx_x    = idx_out[1];
  assign idx_y    = idx_out[0];
  assign mask_x_q = mask_out[1];
  assign mask_y_q = mask_out[0];
  assign acc_hi   = acc[ACC_W-1:LO_W];
  assign acc_lo   = acc[LO_W-1:0];

endmodule

// File: rtl/frac_mac_chk.sv
module frac_mac_chk #(
  parameter int HI_W   = 20,
  parameter int LO_W   = 16,
  parameter int FRAC_W = 31,
  parameter int IDX_W  = 8
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             mac_start,
  input logic             sat_en,
  input logic             acc_hi_load,
  input logic             acc_lo_load,
  input logic [LO_W-1:0]  acc_lo_data,
  input logic             flag_clr,
  input logic             idx_load,
  input logic [HI_W-1:0]  acc_hi,
  input logic [LO_W-1:0]  acc_lo,
  input logic             ovf_mac,
  input logic             ovf_ext,
  input logic [IDX_W-1:0] idx_x,
  input logic [IDX_W-1:0] idx_y,
  input logic [IDX_W-1:0] mask_x_q,
  input logic [IDX_W-1:0] mask_y_q
);

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!mac_start && !acc_hi_load && !acc_lo_load) |=> $stable({acc_hi, acc_lo}));

  p_load_wins_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mac_start && acc_lo_load && !acc_hi_load) |=>
      (acc_lo == $past(acc_lo_data)) && $stable(acc_hi) && $stable(idx_x) && $stable(idx_y));

  p_clamp_range_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mac_start && sat_en && !acc_hi_load && !acc_lo_load) |=>
      ((&acc_hi[HI_W-1:FRAC_W-LO_W]) || !(|acc_hi[HI_W-1:FRAC_W-LO_W])));

  p_ext_sticky_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ovf_ext && !flag_clr) |=> ovf_ext);

  p_mac_sticky_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ovf_mac && !flag_clr) |=> ovf_mac);

  p_clear_wins_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flag_clr |=> (!ovf_mac && !ovf_ext));

  p_x_outside_mask_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !idx_load |=> (((idx_x ^ $past(idx_x)) & ~$past(mask_x_q)) == '0));

  p_y_outside_mask_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !idx_load |=> (((idx_y ^ $past(idx_y)) & ~$past(mask_y_q)) == '0));

endmodule

bind frac_mac frac_mac_chk #(
  .HI_W   (HI_W),
  .LO_W   (LO_W),
  .FRAC_W (FRAC_W),
  .IDX_W  (IDX_W)
) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .mac_start   (mac_start),
  .sat_en      (sat_en),
  .acc_hi_load (acc_hi_load),
  .acc_lo_load (acc_lo_load),
  .acc_lo_data (acc_lo_data),
  .flag_clr    (flag_clr),
  .idx_load    (idx_load),
  .acc_hi      (acc_hi),
  .acc_lo      (acc_lo),
  .ovf_mac     (ovf_mac),
  .ovf_ext     (ovf_ext),
  .idx_x       (idx_x),
  .idx_y       (idx_y),
  .mask_x_q    (mask_x_q),
  .mask_y_q    (mask_y_q)
);

// File: tb/tb_frac_mac.sv
module tb_frac_mac;

  logic        clk;
  logic        rst_n;
  logic        op_a_load, op_b_load, acc_hi_load, acc_lo_load;
  logic [15:0] op_a_data, op_b_data, acc_lo_data, mask_data;
  logic [19:0] acc_hi_data;
  logic        mac_start, sat_en, flag_clr, mask_load, idx_load;
  logic [7:0]  idx_x_data, idx_y_data, step_x, step_y;
  logic [19:0] acc_hi;
  logic [15:0] acc_lo;
  logic        ovf_mac, ovf_ext;
  logic [7:0]  idx_x, idx_y;

  int n_chk  = 0;
  int n_fail = 0;

  frac_mac dut (
    .clk(clk), .rst_n(rst_n),
    .op_a_load(op_a_load), .op_a_data(op_a_data),
    .op_b_load(op_b_load), .op_b_data(op_b_data),
    .acc_hi_load(acc_hi_load), .acc_hi_data(acc_hi_data),
    .acc_lo_load(acc_lo_load), .acc_lo_data(acc_lo_data),
    .mac_start(mac_start), .sat_en(sat_en), .flag_clr(flag_clr),
    .mask_load(mask_load), .mask_data(mask_data),
    .idx_load(idx_load), .idx_x_data(idx_x_data), .idx_y_data(idx_y_data),
    .step_x(step_x), .step_y(step_y),
    .acc_hi(acc_hi), .acc_lo(acc_lo), .ovf_mac(ovf_mac), .ovf_ext(ovf_ext),
    .idx_x(idx_x), .idx_y(idx_y)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  // {acc[35:0], a[15:0], b[15:0], sat}
  localparam int NVEC = 10;
  localparam logic [68:0] VEC [NVEC] = '{
    {36'h0_0000_0000, 16'h4000, 16'h4000, 1'b0},
    {36'h0_1000_0000, 16'hC000, 16'h4000, 1'b0},
    {36'h0_7000_0000, 16'h4000, 16'h4000, 1'b1},
    {36'h0_7000_0000, 16'h4000, 16'h4000, 1'b0},
    {36'hF_9000_0000, 16'hC000, 16'h4000, 1'b1},
    {36'h0_0000_0000, 16'h8000, 16'h8000, 1'b0},
    {36'h7_FFFF_FFFF, 16'h4000, 16'h4000, 1'b0},
    {36'h7_FFFF_FFFF, 16'h4000, 16'h4000, 1'b1},
    {36'h8_0000_0000, 16'hC000, 16'h4000, 1'b0},
    {36'h0_1234_5678, 16'h7FFF, 16'h8001, 1'b1}
  };

  // Returns {wide_ovf, frac_ovf, result[35:0]}
  function automatic logic [37:0] model(input logic [35:0] acc, input logic [15:0] a,
                                        input logic [15:0] b, input logic sat);
    longint s, p, hi_lim, lo_lim, wide_lim;
    logic [35:0] r;
    logic e, m;
    s        = longint'($signed({{28{acc[35]}}, acc}));
    p        = longint'($signed(a)) * longint'($signed(b)) * 2;
    s        = s + p;
    hi_lim   = (longint'(1) <<< 31) - 1;
    lo_lim   = -(longint'(1) <<< 31);
    wide_lim = longint'(1) <<< 35;
    e = (s > hi_lim) || (s < lo_lim);
    m = (s >= wide_lim) || (s < -wide_lim);
    if (sat && e) r = (s > 0) ? 36'h0_7FFF_FFFF : 36'hF_8000_0000;
    else          r = s[35:0];
    return {m, e, r};
  endfunction

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_inputs;
    op_a_load = 0; op_b_load = 0; acc_hi_load = 0; acc_lo_load = 0;
    mac_start = 0; flag_clr = 0; mask_load = 0; idx_load = 0;
  endtask

  task automatic load_acc(input logic [35:0] v);
    acc_hi_load = 1; acc_hi_data = v[35:16];
    acc_lo_load = 1; acc_lo_data = v[15:0];
    tick;
    acc_hi_load = 0; acc_lo_load = 0;
  endtask

  task automatic load_ops(input logic [15:0] a, input logic [15:0] b);
    op_a_load = 1; op_a_data = a;
    op_b_load = 1; op_b_data = b;
    tick;
    op_a_load = 0; op_b_load = 0;
  endtask

  task automatic pulse_start;
    mac_start = 1;
    tick;
    mac_start = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    rst_n = 0;
    idle_inputs();
    sat_en = 0;
    op_a_data = 0; op_b_data = 0; acc_hi_data = 0; acc_lo_data = 0;
    mask_data = 0; idx_x_data = 0; idx_y_data = 0; step_x = 0; step_y = 0;
    repeat (3) tick;
    // R1: state during reset
    chk("R1 acc in reset", {acc_hi, acc_lo}, 36'h0);
    rst_n = 1;
    tick;
    // R1: first edges after release still in reset, try to load
    acc_hi_load = 1; acc_hi_data = 20'hFFFFF;
    tick;
    acc_hi_load = 0;
    chk("R1 synchronised release", {44'h0, acc_hi}, 64'h0);
    tick; tick;
    chk("R1 acc", {acc_hi, acc_lo}, 36'h0);
    chk("R1 flags", {ovf_mac, ovf_ext}, 2'b00);
    chk("R1 indices", {idx_x, idx_y}, 16'h0);
    // R1: operands zero -> start adds nothing, masks zero -> indices fixed
    step_x = 8'h05; step_y = 8'h07;
    pulse_start();
    chk("R1 operand regs zero", {acc_hi, acc_lo}, 36'h0);
    chk("R1 masks zero", {idx_x, idx_y}, 16'h0);

    // Vector table: R3, R6, R7, R8, R9
    for (int i = 0; i < NVEC; i++) begin
      logic [68:0] v;
      logic [37:0] e;
      v = VEC[i];
      flag_clr = 1;
      load_ops(v[32:17], v[16:1]);
      flag_clr = 0;
      load_acc(v[68:33]);
      sat_en = v[0];
      pulse_start();
      e = model(v[68:33], v[32:17], v[16:1], v[0]);
      if (v[0]) chk("R7 clamp result", {acc_hi, acc_lo}, e[35:0]);
      else      chk("R6 wrap result",  {acc_hi, acc_lo}, e[35:0]);
      chk("R3 accumulate", {acc_hi, acc_lo}, e[35:0]);
      chk("R8 ext flag", ovf_ext, e[36]);
      chk("R9 mac flag", ovf_mac, e[37]);
    end
    sat_en = 0;

    // R2: operands held across two starts
    flag_clr = 1; tick; flag_clr = 0;
    load_acc(36'h0);
    load_ops(16'h4000, 16'h2000);
    pulse_start();
    pulse_start();
    chk("R2 operand hold", {acc_hi, acc_lo}, 36'h0_2000_0000);

    // R4: independent halves
    acc_lo_load = 1; acc_lo_data = 16'h1357; tick; acc_lo_load = 0;
    chk("R4 low load keeps high", {acc_hi, acc_lo}, 36'h0_2000_1357);
    acc_hi_load = 1; acc_hi_data = 20'hABCDE; tick; acc_hi_load = 0;
    chk("R4 high load keeps low", {acc_hi, acc_lo}, 36'hA_BCDE_1357);

    // R5: load collides with start
    mask_load = 1; mask_data = 16'hFFFF;
    idx_load = 1; idx_x_data = 8'h10; idx_y_data = 8'h20;
    step_x = 8'h01; step_y = 8'h01;
    tick;
    mask_load = 0; idx_load = 0;
    mac_start = 1; acc_lo_load = 1; acc_lo_data = 16'h2468;
    tick;
    mac_start = 0; acc_lo_load = 0;
    chk("R5 load wins", {acc_hi, acc_lo}, 36'hA_BCDE_2468);
    chk("R5 indices unchanged", {idx_x, idx_y}, 16'h1020);
    chk("R5 flags unchanged", {ovf_mac, ovf_ext}, 2'b00);

    // R10: clear, then clear colliding with set
    load_acc(36'h0_7000_0000);
    load_ops(16'h4000, 16'h4000);
    pulse_start();
    chk("R8 ext set", ovf_ext, 1'b1);
    flag_clr = 1; tick; flag_clr = 0;
    chk("R10 clear", {ovf_mac, ovf_ext}, 2'b00);
    load_acc(36'h7_FFFF_FFFF);
    flag_clr = 1; mac_start = 1;
    tick;
    flag_clr = 0; mac_start = 0;
    chk("R10 clear wins over set", {ovf_mac, ovf_ext}, 2'b00);
    chk("R10 acc still updated", {acc_hi, acc_lo}, 36'h8_1FFF_FFFF);
    pulse_start();
    chk("R8 ext sets again", ovf_ext, 1'b1);
    chk("R9 no wide ovf", ovf_mac, 1'b0);

    // R11: modulo stepping, x mask in [15:8], y mask in [7:0]
    mask_load = 1; mask_data = 16'h0F07;
    idx_load = 1; idx_x_data = 8'h2E; idx_y_data = 8'h47;
    step_x = 8'h03; step_y = 8'h01;
    tick;
    mask_load = 0; idx_load = 0;
    pulse_start();
    chk("R11 wrap step 1", {idx_x, idx_y}, 16'h2140);
    pulse_start();
    chk("R11 step 2", {idx_x, idx_y}, 16'h2441);
    mask_load = 1; mask_data = 16'hFF00;
    idx_load = 1; idx_x_data = 8'hFE; idx_y_data = 8'h33;
    tick;
    mask_load = 0; idx_load = 0;
    pulse_start();
    chk("R11 full mask wrap, zero mask holds", {idx_x, idx_y}, 16'h0133);

    // R12: index load beats step
    idx_load = 1; idx_x_data = 8'h5A; idx_y_data = 8'hA5; mac_start = 1;
    tick;
    idx_load = 0; mac_start = 0;
    chk("R12 load beats step", {idx_x, idx_y}, 16'h5AA5);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule